// File: doc/BRIEF.md
# Byte-Command JTAG Shift Engine

The block is a JTAG master that a host controls entirely with single-byte writes. A host writes command bytes to the command location. A command byte either updates a configuration setting or starts a short burst of TCK cycles. The configuration settings are reset pin control, output port enable, clock speed and the length of the next shift. The bursts are a five-bit TMS walk that carries one TDI value, or one to four idle clocks. A write to the data location shifts that byte, or a programmed part of it, out on TDI with TMS low, and captures TDO into a read register.

The host moves the TAP with a handful of byte writes instead of toggling pins bit by bit. It polls the status byte for a busy flag before it issues the next command, and it reads captured TDO bits from the data location. Writes that arrive while a burst is still clocking are discarded. Each discarded write sets a sticky overrun flag, and a read of the status location clears that flag.

Top module: `jtag_byte_engine`

## Requirements
- R1: After reset the status byte and the read register are 0x00. TCK, TMS and TDI are low. Both reset pins are released with their output enables low. Return-clock mode is off. The shift length is eight bits.
- R2: A command byte 0000_dcba sets the reset pins: a=1 asserts SRST and c=1 asserts TRST. Bit b selects the SRST style and bit d the TRST style. Style 0 is open-drain: the output enable equals the asserted state and the level is 0. Style 1 is push-pull: the output enable is 1 and the active-low level is the inverse of the asserted state.
- R3: A command byte 0001_xpex sets bit e (bit 1) as the return-clock mode output and bit p (bit 2) as the port enable. While the port is disabled, TCK, TMS and TDI stay low, but commands still run for their normal duration.
- R4: A command byte 0010_ssss sets the speed s. Each TCK phase lasts s+1 system clocks, so a burst of N bits keeps busy high for exactly 2·N·(s+1) clocks.
- R5: A command byte 0011_xlll makes the next data shift lll+1 bits long. After that shift the length returns to eight bits.
- R6: A command byte 01tm_mmmm clocks five TCK cycles. TMS takes bits 4:0, LSB first, and TDI holds bit 5 on all five cycles. Afterwards the read register is {TDO of the first cycle, 7'b0}.
- R7: A command byte 10nn_xxxx clocks nn+1 TCK cycles with TMS and TDI low, and it leaves the read register unchanged.
- R8: A write to the data location shifts the byte LSB first on TDI with TMS low, for the programmed length n. The read register then holds the n captured TDO bits in bits 7 down to 8-n, with the oldest bit lowest, and zeros below them.
- R9: TMS and TDI change only while TCK is low, meaning on a falling edge or at the start of a burst. TDO is sampled on the rising edge of TCK.
- R10: Status bit 7 reads 1 from the cycle after a burst is accepted until its last TCK falling edge, and reads 0 otherwise.
- R11: Any write that arrives while busy is discarded and sets status bit 6. A status read clears bit 6.
- R12: Command bytes of the form 11xx_xxxx have no effect on configuration, pins or status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_wr | input | 1 | Write strobe, one cycle per byte |
| host_rd | input | 1 | Read strobe; when host_sel is 0 it clears the overrun flag |
| host_sel | input | 1 | 0: command write / status read, 1: data write / capture read |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Status byte (sel 0) or read register (sel 1), combinational |
| tdo_i | input | 1 | Test data from the target |
| tck_o | output | 1 | Test clock |
| tms_o | output | 1 | Test mode select |
| tdi_o | output | 1 | Test data to the target |
| retclk_en_o | output | 1 | Return-clock mode setting |
| srst_n_o | output | 1 | System reset level, active low |
| srst_oe_o | output | 1 | System reset output enable |
| trst_n_o | output | 1 | Test reset level, active low |
| trst_oe_o | output | 1 | Test reset output enable |

## Verification
The assertions take for granted that TDO is synchronous to the system clock and settles before the edge where TCK rises. They also assume the host holds each write strobe for exactly one cycle. The bench drives TDO from a rotating pattern that advances only after each TCK rising edge, so the value the engine samples is always the one presented during the low phase. The random phase keeps the speed setting small and, apart from the directed overrun case, waits for busy to clear before each write, so every accepted burst can be checked bit by bit.

// File: rtl/jtag_eng_pkg.sv
package jtag_eng_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [1:0] {
    CAP_NONE  = 2'd0,
    CAP_FIRST = 2'd1,
    CAP_ALL   = 2'd2
  } cap_mode_e;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_RST  = 3'd1,
    OP_FSM  = 3'd2,
    OP_SPD  = 3'd3,
    OP_LEN  = 3'd4,
    OP_JOB  = 3'd5
  } op_e;

  typedef struct packed {
    logic [CNT_W-1:0]  nbits;
    logic [BYTE_W-1:0] tms;
    logic [BYTE_W-1:0] tdi;
    cap_mode_e         cap;
  } job_t;
endpackage

// File: rtl/jtag_cmd_decode.sv
module jtag_cmd_decode
  import jtag_eng_pkg::*;
(
  input  logic              cmd_valid,
  input  logic              data_valid,
  input  logic [BYTE_W-1:0] wbyte,
  input  logic [2:0]        len_m1,
  output op_e               op,
  output job_t              job
);
  always_comb begin
    op        = OP_NONE;
    job.nbits = '0;
    job.tms   = '0;
    job.tdi   = '0;
    job.cap   = CAP_NONE;
    if (data_valid) begin
      op        = OP_JOB;
      job.nbits = CNT_W'(len_m1) + CNT_W'(1);
      job.tdi   = wbyte;
      job.cap   = CAP_ALL;
    end else if (cmd_valid) begin
      case (wbyte[7:6])
        2'b00: begin
          case (wbyte[5:4])
            2'b00:   op = OP_RST;
            2'b01:   op = OP_FSM;
            2'b10:   op = OP_SPD;
            default: op = OP_LEN;
          endcase
        end
        2'b01: begin
          op        = OP_JOB;
          job.nbits = CNT_W'(5);
          job.tms   = BYTE_W'(wbyte[4:0]);
          job.tdi   = {BYTE_W{wbyte[5]}};
          job.cap   = CAP_FIRST;
        end
        2'b10: begin
          op        = OP_JOB;
          job.nbits = CNT_W'(wbyte[5:4]) + CNT_W'(1);
        end
        default: op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/jtag_tck_gen.sv
module jtag_tck_gen #(
  parameter int SPD_W = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] nbits,
  input  logic [SPD_W-1:0] half,
  output logic             tck,
  output logic             active,
  output logic             rise,
  output logic             step,
  output logic             done
);
  logic             active_q, active_d;
  logic             tck_q, tck_d;
  logic [SPD_W-1:0] ph_q, ph_d;
  logic [CNT_W-1:0] bits_q, bits_d;
  logic             at_end, fall, ld;

  assign at_end = active_q && (ph_q == half);
  assign rise   = at_end && !tck_q;
  assign fall   = at_end && tck_q;
  assign step   = fall && (bits_q != '0);
  assign done   = fall && (bits_q == '0);
  assign ld     = start || active_q;

  always_comb begin
    active_d = active_q;
    tck_d    = tck_q;
    ph_d     = ph_q;
    bits_d   = bits_q;
    if (start) begin
      active_d = 1'b1;
      tck_d    = 1'b0;
      ph_d     = '0;
      bits_d   = nbits - CNT_W'(1);
    end else if (active_q) begin
      if (at_end) begin
        ph_d  = '0;
        tck_d = !tck_q;
        if (done) active_d = 1'b0;
        if (step) bits_d = bits_q - CNT_W'(1);
      end else begin
        ph_d = ph_q + SPD_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      tck_q    <= 1'b0;
      ph_q     <= '0;
      bits_q   <= '0;
    end else if (ld) begin
      active_q <= active_d;
      tck_q    <= tck_d;
      ph_q     <= ph_d;
      bits_q   <= bits_d;
    end
  end

  assign tck    = tck_q;
  assign active = active_q;

  assert_tck_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> !tck_q);
  assert_start_only_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active_q);
endmodule

// File: rtl/jtag_shift_path.sv
module jtag_shift_path
  import jtag_eng_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  job_t              job,
  input  logic              step,
  input  logic              rise,
  input  logic              tdo,
  output logic              tms,
  output logic              tdi,
  output logic [BYTE_W-1:0] rx
);
  logic [BYTE_W-1:0] tms_sr_q, tms_sr_d, tdi_sr_q, tdi_sr_d, rx_q, rx_d;
  cap_mode_e         cap_q, cap_d;
  logic              first_q, first_d, tms_q, tms_d, tdi_q, tdi_d, ld;

  assign ld = start || step || rise;

  always_comb begin
    tms_sr_d = tms_sr_q;
    tdi_sr_d = tdi_sr_q;
    rx_d     = rx_q;
    cap_d    = cap_q;
    first_d  = first_q;
    tms_d    = tms_q;
    tdi_d    = tdi_q;
    if (start) begin
      tms_d    = job.tms[0];
      tdi_d    = job.tdi[0];
      tms_sr_d = job.tms >> 1;
      tdi_sr_d = job.tdi >> 1;
      cap_d    = job.cap;
      first_d  = 1'b1;
      if (job.cap == CAP_ALL) rx_d = '0;
    end else begin
      if (step) begin
        tms_d    = tms_sr_q[0];
        tdi_d    = tdi_sr_q[0];
        tms_sr_d = tms_sr_q >> 1;
        tdi_sr_d = tdi_sr_q >> 1;
      end
      if (rise) begin
        first_d = 1'b0;
        if (cap_q == CAP_ALL)
          rx_d = {tdo, rx_q[BYTE_W-1:1]};
        else if ((cap_q == CAP_FIRST) && first_q)
          rx_d = {tdo, {(BYTE_W-1){1'b0}}};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tms_sr_q <= '0;
      tdi_sr_q <= '0;
      rx_q     <= '0;
      cap_q    <= CAP_NONE;
      first_q  <= 1'b0;
      tms_q    <= 1'b0;
      tdi_q    <= 1'b0;
    end else if (ld) begin
      tms_sr_q <= tms_sr_d;
      tdi_sr_q <= tdi_sr_d;
      rx_q     <= rx_d;
      cap_q    <= cap_d;
      first_q  <= first_d;
      tms_q    <= tms_d;
      tdi_q    <= tdi_d;
    end
  end

  assign tms = tms_q;
  assign tdi = tdi_q;
  assign rx  = rx_q;

  assert_data_tms_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_q == CAP_ALL) |-> !tms_q);
  assert_rx_hold_on_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !start) |=> $stable(rx_q));
endmodule

// File: rtl/jtag_byte_engine.sv
module jtag_byte_engine
  import jtag_eng_pkg::*;
#(
  parameter int SPD_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_sel,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata,
  input  logic              tdo_i,
  output logic              tck_o,
  output logic              tms_o,
  output logic              tdi_o,
  output logic              retclk_en_o,
  output logic              srst_n_o,
  output logic              srst_oe_o,
  output logic              trst_n_o,
  output logic              trst_oe_o
);
  localparam logic [2:0] LEN_FULL = 3'(BYTE_W - 1);

  logic [1:0]       rsync_q;
  logic             rst_ns;
  logic [3:0]       rst_ctl_q, rst_ctl_d;
  logic [1:0]       fsm_q, fsm_d;
  logic [SPD_W-1:0] spd_q, spd_d;
  logic [2:0]       len_q, len_d;
  logic             ovr_q, ovr_d;
  logic             busy, accepted, cmd_valid, data_valid, job_start, cfg_ld;
  logic             tck_int, tms_int, tdi_int, rise, step, done;
  logic [BYTE_W-1:0] rx;
  op_e              op;
  job_t             job;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  assign accepted   = host_wr && !busy;
  assign cmd_valid  = accepted && !host_sel;
  assign data_valid = accepted && host_sel;
  assign job_start  = (op == OP_JOB);

  jtag_cmd_decode i_decode (
    .cmd_valid (cmd_valid),
    .data_valid(data_valid),
    .wbyte     (host_wdata),
    .len_m1    (len_q),
    .op        (op),
    .job       (job)
  );

  jtag_tck_gen #(.SPD_W(SPD_W), .CNT_W(CNT_W)) i_tck (
    .clk   (clk),
    .rst_n (rst_ns),
    .start (job_start),
    .nbits (job.nbits),
    .half  (spd_q),
    .tck   (tck_int),
    .active(busy),
    .rise  (rise),
    .step  (step),
    .done  (done)
  );

  jtag_shift_path i_shift (
    .clk  (clk),
    .rst_n(rst_ns),
    .start(job_start),
    .job  (job),
    .step (step),
    .rise (rise),
    .tdo  (tdo_i),
    .tms  (tms_int),
    .tdi  (tdi_int),
    .rx   (rx)
  );

  always_comb begin
    rst_ctl_d = rst_ctl_q;
    fsm_d     = fsm_q;
    spd_d     = spd_q;
    len_d     = len_q;
    case (op)
      OP_RST:  rst_ctl_d = host_wdata[3:0];
      OP_FSM:  fsm_d     = host_wdata[2:1];
      OP_SPD:  spd_d     = SPD_W'(host_wdata[3:0]);
      OP_LEN:  len_d     = host_wdata[2:0];
      default: ;
    endcase
    if (data_valid) len_d = LEN_FULL;
    if (host_wr && busy) ovr_d = 1'b1;
    else if (host_rd && !host_sel) ovr_d = 1'b0;
    else ovr_d = ovr_q;
  end

  assign cfg_ld = accepted;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      rst_ctl_q <= '0;
      fsm_q     <= '0;
      spd_q     <= '0;
      len_q     <= LEN_FULL;
    end else if (cfg_ld) begin
      rst_ctl_q <= rst_ctl_d;
      fsm_q     <= fsm_d;
      spd_q     <= spd_d;
      len_q     <= len_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) ovr_q <= 1'b0;
    else         ovr_q <= ovr_d;
  end

  assign tck_o       = tck_int && fsm_q[1];
  assign tms_o       = tms_int && fsm_q[1];
  assign tdi_o       = tdi_int && fsm_q[1];
  assign retclk_en_o = fsm_q[0];

  assign srst_oe_o = rst_ctl_q[1] || rst_ctl_q[0];
  assign srst_n_o  = rst_ctl_q[1] && !rst_ctl_q[0];
  assign trst_oe_o = rst_ctl_q[3] || rst_ctl_q[2];
  assign trst_n_o  = rst_ctl_q[3] && !rst_ctl_q[2];

  assign host_rdata = host_sel ? rx : {busy, ovr_q, {(BYTE_W-2){1'b0}}};

  assert_ignore_busy_R11: assert property (@(posedge clk) disable iff (!rst_ns)
    (host_wr && busy) |=> (ovr_q && $stable(len_q) && $stable(spd_q)));
  assert_len_revert_R5: assert property (@(posedge clk) disable iff (!rst_ns)
    data_valid |=> (len_q == LEN_FULL));
  assert_tck_needs_busy_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(tck_o) |-> busy);
  assert_done_clears_busy_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    done |=> !busy);
endmodule

// File: tb/test_jtag_byte_engine.sv
`timescale 1ns/1ps
module test_jtag_byte_engine;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0, host_rd = 1'b0, host_sel = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic tdo_i;
  logic tck_o, tms_o, tdi_o, retclk_en_o, srst_n_o, srst_oe_o, trst_n_o, trst_oe_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] dev_pat = 16'hB38D;
  logic        tms_log [0:2047];
  logic        tdi_log [0:2047];
  int          lc = 0;
  logic        prev_tms = 1'b0, prev_tdi = 1'b0;
  int          viol = 0;
  bit          pin_hi = 0;

  always #4 clk = ~clk;

  jtag_byte_engine i_jtag_byte_engine (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tdo_i(tdo_i), .tck_o(tck_o), .tms_o(tms_o), .tdi_o(tdi_o),
    .retclk_en_o(retclk_en_o), .srst_n_o(srst_n_o), .srst_oe_o(srst_oe_o),
    .trst_n_o(trst_n_o), .trst_oe_o(trst_oe_o)
  );

  assign tdo_i = dev_pat[0];

  always @(posedge tck_o) begin
    tms_log[lc & 2047] = tms_o;
    tdi_log[lc & 2047] = tdi_o;
    lc = lc + 1;
    dev_pat = {dev_pat[0], dev_pat[15:1]};
  end

  always @(negedge clk) begin
    if (tck_o && ((tms_o != prev_tms) || (tdi_o != prev_tdi))) viol++;
    if (tck_o || tms_o || tdi_o) pin_hi = 1;
    prev_tms = tms_o;
    prev_tdi = tdi_o;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    @(negedge clk);
    host_sel = sel; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic peek(input logic sel, output logic [7:0] v);
    host_sel = sel;
    #1;
    v = host_rdata;
  endtask

  task automatic rd_status(output logic [7:0] v);
    @(negedge clk);
    host_sel = 1'b0; host_rd = 1'b1;
    #1;
    v = host_rdata;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  task automatic wait_idle(output int cnt);
    logic [7:0] s;
    cnt = 0;
    peek(1'b0, s);
    while (s[7]) begin
      cnt++;
      @(negedge clk);
      peek(1'b0, s);
    end
  endtask

  function automatic logic [7:0] exp_rx(input logic [15:0] p, input int n);
    logic [7:0] r = 8'h00;
    for (int i = 0; i < n; i++) r[8 - n + i] = p[i];
    return r;
  endfunction

  task automatic do_job(input string req, input logic sel, input logic [7:0] b,
                        input int n, input logic [7:0] etms, input logic [7:0] etdi,
                        input int spd, output logic [15:0] p);
    int cnt, lc0;
    logic [7:0] gt, gd, s;
    p = dev_pat;
    lc0 = lc;
    wr(sel, b);
    peek(1'b0, s);
    check({"R10 busy after accept ", req}, {31'd0, s[7]}, 32'd1);
    wait_idle(cnt);
    check({"R4 busy length ", req}, cnt, n * 2 * (spd + 1));
    check({"bit count ", req}, lc - lc0, n);
    gt = 8'h00; gd = 8'h00;
    for (int i = 0; i < n; i++) begin
      gt[i] = tms_log[(lc0 + i) & 2047];
      gd[i] = tdi_log[(lc0 + i) & 2047];
    end
    check({"TMS pattern ", req}, gt, etms & ((8'h01 << n) - 8'h01));
    check({"TDI pattern ", req}, gd, etdi & ((8'h01 << n) - 8'h01));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, v2, b;
    logic [15:0] p;
    int cnt, lc0, s, n;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    peek(1'b0, v); check("R1 status", v, 8'h00);
    peek(1'b1, v); check("R1 read reg", v, 8'h00);
    check("R1 pins", {tck_o, tms_o, tdi_o, retclk_en_o, srst_oe_o, srst_n_o, trst_oe_o, trst_n_o}, 0);

    lc0 = lc; pin_hi = 0;
    wr(1'b0, 8'h7F);
    wait_idle(cnt);
    check("R3 disabled still times", cnt, 10);
    check("R3 disabled no TCK", lc - lc0, 0);
    check("R3 disabled pins low", {31'd0, pin_hi}, 0);

    wr(1'b0, 8'h16); check("R3 retclk on", {31'd0, retclk_en_o}, 1);
    wr(1'b0, 8'h14); check("R3 retclk off", {31'd0, retclk_en_o}, 0);

    wr(1'b0, 8'h05); check("R2 open-drain asserted", {srst_oe_o, srst_n_o, trst_oe_o, trst_n_o}, 4'b1010);
    wr(1'b0, 8'h0F); check("R2 push-pull asserted", {srst_oe_o, srst_n_o, trst_oe_o, trst_n_o}, 4'b1010);
    wr(1'b0, 8'h0A); check("R2 push-pull released", {srst_oe_o, srst_n_o, trst_oe_o, trst_n_o}, 4'b1111);
    wr(1'b0, 8'h01); check("R2 mixed", {srst_oe_o, srst_n_o, trst_oe_o, trst_n_o}, 4'b1000);
    wr(1'b0, 8'h00); check("R2 open-drain released", {srst_oe_o, srst_n_o, trst_oe_o, trst_n_o}, 4'b0000);

    wr(1'b0, 8'h22);
    do_job("R8 speed2 data", 1'b1, 8'hC6, 8, 8'h00, 8'hC6, 2, p);
    peek(1'b1, v); check("R8 capture full byte", v, exp_rx(p, 8));

    wr(1'b0, 8'h20);
    wr(1'b0, 8'h32);
    do_job("R5 three-bit shift", 1'b1, 8'hFD, 3, 8'h00, 8'hFD, 0, p);
    peek(1'b1, v); check("R8 partial capture left packed", v, exp_rx(p, 3));
    do_job("R5 length back to eight", 1'b1, 8'h5A, 8, 8'h00, 8'h5A, 0, p);

    do_job("R6 tms burst", 1'b0, 8'h6B, 5, 8'h0B, 8'hFF, 0, p);
    peek(1'b1, v); check("R6 first TDO in bit7", v, {p[0], 7'd0});
    do_job("R7 idle three", 1'b0, 8'hA9, 3, 8'h00, 8'h00, 0, p);
    peek(1'b1, v2); check("R7 read reg unchanged", v2, v);

    wr(1'b0, 8'h23);
    lc0 = lc;
    wr(1'b1, 8'hA5);
    wr(1'b0, 8'h31);
    wr(1'b1, 8'h3C);
    peek(1'b0, v); check("R11 overrun while busy", v, 8'hC0);
    wait_idle(cnt);
    check("R11 only first shift ran", lc - lc0, 8);
    v2 = 8'h00;
    for (int i = 0; i < 8; i++) v2[i] = tdi_log[(lc0 + i) & 2047];
    check("R11 discarded data write", v2, 8'hA5);
    rd_status(v); check("R11 status read shows overrun", v, 8'h40);
    peek(1'b0, v); check("R11 cleared by read", v, 8'h00);
    wr(1'b0, 8'h20);
    do_job("R11 length write discarded", 1'b1, 8'h81, 8, 8'h00, 8'h81, 0, p);

    lc0 = lc;
    wr(1'b0, 8'hC3);
    peek(1'b0, v); check("R12 no busy", v, 8'h00);
    check("R12 no TCK", lc - lc0, 0);
    check("R12 pins unchanged", {srst_oe_o, trst_oe_o, retclk_en_o}, 3'b000);
    do_job("R12 length unchanged", 1'b1, 8'h3E, 8, 8'h00, 8'h3E, 0, p);

    for (int it = 0; it < 30; it++) begin
      s = $urandom % 4;
      wr(1'b0, 8'h20 | 8'(s));
      case ($urandom % 3)
        0: begin
          n = ($urandom % 8) + 1;
          if (n != 8) wr(1'b0, 8'h30 | 8'(n - 1));
          b = 8'($urandom);
          do_job("R8 random data", 1'b1, b, n, 8'h00, b, s, p);
          peek(1'b1, v); check("R8 random capture", v, exp_rx(p, n));
        end
        1: begin
          b = 8'h40 | 8'($urandom % 64);
          do_job("R6 random tms", 1'b0, b, 5, {3'd0, b[4:0]}, {8{b[5]}}, s, p);
          peek(1'b1, v); check("R6 random capture", v, {p[0], 7'd0});
        end
        default: begin
          n = ($urandom % 4) + 1;
          b = 8'h80 | 8'((n - 1) << 4) | 8'($urandom % 16);
          peek(1'b1, v2);
          do_job("R7 random idle", 1'b0, b, n, 8'h00, 8'h00, s, p);
          peek(1'b1, v); check("R7 random read unchanged", v, v2);
        end
      endcase
    end

    check("R9 TMS/TDI change only with TCK low", viol, 0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule